// File: doc/BRIEF.md
# Character Display Access Unit

This block is the host-side access logic of a character display controller. A host reaches it over a parallel bus that has a register-select line, a read/write line, an enable strobe and eight data lines. The unit executes an instruction when the strobe falls. It holds a single address counter that both internal memories share: a display-data memory with 128 entries of 8 bits, and a glyph memory with 128 entries of 5 bits. It also holds a data register that is filled ahead of each read, an entry-mode bit that sets the step direction, and a busy flag.

Control is one state machine with four states. `ST_IDLE` waits for a strobe fall. `ST_EXEC` carries out the captured instruction. `ST_FETCH` loads the data register from the memory at the current counter. `ST_BUSY` counts out the hold time. The transitions are: idle→exec when an executable instruction arrives while not busy; exec→fetch after a set-address or read-data instruction; exec→busy after a write or entry-mode instruction; fetch→busy always; busy→idle when the hold counter reaches zero. The busy flag is high in every state except `ST_IDLE`.

Top module: `lcd_access_unit`

## Requirements
- R1: After reset the counter is 0, the busy flag is 0, the data register is 0, stepping is upward, display memory is selected, and both memories read as zero.
- R2: With select=0 and write, a data byte with bit 7 set loads bits 6..0 into the counter and selects display memory.
- R3: With select=0 and write, a byte with bits 7..6 = 01 loads only counter bits 5..0 from data bits 5..0 and selects glyph memory. Counter bit 6 keeps its old value, whether that value came from a display-address load or from stepping.
- R4: With select=0 and read, the bus carries the busy flag on bit 7 and the full counter on bits 6..0 while the strobe is high.
- R5: With select=1 and write, the byte is stored at the counter in the selected memory, and the counter then steps by one with wraparound modulo 128.
- R6: A glyph-memory write keeps data bits 4..0 only. Glyph reads return bits 7..5 as zero.
- R7: With select=0 and write, a byte of the form 000001dx sets the step direction: d=1 counts up, d=0 counts down.
- R8: With select=1 and read, the bus carries the data register while the strobe is high. After the strobe falls, the counter steps and the data register is reloaded from the new address.
- R9: Only the two set-address instructions and read-data reload the data register. Writes and entry-mode leave it unchanged.
- R10: An executed instruction holds the busy flag for 1+F+BUSY_CYCLES clocks after the strobe-fall clock, where F=1 for instructions that reload the data register and F=0 otherwise. Instructions that arrive while busy are dropped.
- R11: Other select=0 write codes have no effect and do not raise the busy flag.
- R12: The bus output enable is high exactly while the strobe is high with read selected. The output data is zero whenever it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 memory data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Enable strobe, executes on its fall |
| bus_din | input | DW | Data from host |
| bus_dout | output | DW | Data to host |
| bus_oe | output | 1 | Output enable for the data lines |

## Verification
The bench keeps the default 7-bit counter, so stepping past 127 and below 0 is exercised, and so is the upper half of the glyph memory. It sets BUSY_CYCLES to 3. With a short hold time, a status read placed right after an instruction still lands inside the busy window, and an instruction issued straight after another is dropped. The reference model predicts the busy flag cycle by cycle from the strobe-fall clock. It also covers glyph and display accesses that alternate, including a glyph write sent to the upper half by a stale bit 6.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_FETCH,
        ST_BUSY
    } lcd_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_DD,
        OP_SET_CG,
        OP_ENTRY,
        OP_WRITE,
        OP_READ
    } lcd_op_e;

    typedef struct packed {
        lcd_op_e    op;
        logic [7:0] arg;
    } lcd_instr_t;
endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
    import lcd_pkg::*;
(
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] data,
    output lcd_instr_t instr
);
    always_comb begin
        instr.arg = data;
        instr.op  = OP_NONE;
        unique case ({rs, rw})
            2'b00: begin
                if (data[7])                     instr.op = OP_SET_DD;
                else if (data[6])                instr.op = OP_SET_CG;
                else if (data[7:2] == 6'b000001) instr.op = OP_ENTRY;
                else                             instr.op = OP_NONE;
            end
            2'b10:   instr.op = OP_WRITE;
            2'b11:   instr.op = OP_READ;
            default: instr.op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/lcd_strobe_edge.sv
module lcd_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/lcd_ram.sv
module lcd_ram #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/lcd_access_unit.sv
module lcd_access_unit
    import lcd_pkg::*;
#(
    parameter int  AW          = 7,
    parameter int  DW          = 8,
    parameter int  CGW         = 5,
    parameter int  BUSY_CYCLES = 4,
    localparam int DEPTH       = 1 << AW,
    localparam int CNTW        = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rs,
    input  logic          bus_rw,
    input  logic          bus_en,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe
);
    lcd_state_e      state, state_nxt;
    lcd_instr_t      instr_now, instr_q;
    logic [AW-1:0]   ac;
    logic [AW-1:0]   ac_step;
    logic [DW-1:0]   dr;
    logic            incr;
    logic            sel_cg;
    logic [CNTW-1:0] cnt;
    logic            en_fall;
    logic            accept;
    logic            busy;
    logic            dd_we, cg_we;
    logic [DW-1:0]   dd_q;
    logic [CGW-1:0]  cg_q;
    logic [DW-1:0]   fetch_data;
    logic [DW-1:0]   status_word;

    lcd_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(bus_en),
        .fall  (en_fall)
    );

    lcd_cmd_decode u_dec (
        .rs   (bus_rs),
        .rw   (bus_rw),
        .data (bus_din),
        .instr(instr_now)
    );

    lcd_ram #(.DEPTH(DEPTH), .WIDTH(DW)) u_dd_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (dd_we),
        .addr (ac),
        .wdata(instr_q.arg),
        .rdata(dd_q)
    );

    lcd_ram #(.DEPTH(DEPTH), .WIDTH(CGW)) u_cg_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cg_we),
        .addr (ac),
        .wdata(instr_q.arg[CGW-1:0]),
        .rdata(cg_q)
    );

    assign busy       = (state != ST_IDLE);
    assign accept     = en_fall && (state == ST_IDLE) && (instr_now.op != OP_NONE);
    assign ac_step    = incr ? ac + 1'b1 : ac - 1'b1;
    assign fetch_data = sel_cg ? {{(DW-CGW){1'b0}}, cg_q} : dd_q;
    assign dd_we      = (state == ST_EXEC) && (instr_q.op == OP_WRITE) && !sel_cg;
    assign cg_we      = (state == ST_EXEC) && (instr_q.op == OP_WRITE) && sel_cg;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nxt = ST_EXEC;
            ST_EXEC:  state_nxt = (instr_q.op == OP_SET_DD || instr_q.op == OP_SET_CG ||
                                   instr_q.op == OP_READ) ? ST_FETCH : ST_BUSY;
            ST_FETCH: state_nxt = ST_BUSY;
            ST_BUSY:  if (cnt == '0) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Datapath registers driven by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= '{op: OP_NONE, arg: '0};
            ac      <= '0;
            dr      <= '0;
            incr    <= 1'b1;
            sel_cg  <= 1'b0;
            cnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) instr_q <= instr_now;
                end
                ST_EXEC: begin
                    cnt <= CNTW'(BUSY_CYCLES - 1);
                    unique case (instr_q.op)
                        OP_SET_DD: begin
                            ac     <= instr_q.arg[AW-1:0];
                            sel_cg <= 1'b0;
                        end
                        OP_SET_CG: begin
                            ac[AW-2:0] <= instr_q.arg[AW-2:0];
                            sel_cg     <= 1'b1;
                        end
                        OP_ENTRY:  incr <= instr_q.arg[1];
                        OP_WRITE:  ac   <= ac_step;
                        OP_READ:   ac   <= ac_step;
                        default:   ;
                    endcase
                end
                ST_FETCH: begin
                    dr  <= fetch_data;
                    cnt <= CNTW'(BUSY_CYCLES - 1);
                end
                ST_BUSY: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Bus outputs
    always_comb begin
        status_word         = '0;
        status_word[DW-1]   = busy;
        status_word[AW-1:0] = ac;
        bus_oe              = bus_en & bus_rw;
        if (!bus_oe)     bus_dout = '0;
        else if (bus_rs) bus_dout = dr;
        else             bus_dout = status_word;
    end

    // Checks next to the logic they guard
    assert_cg_keeps_bit6_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && instr_q.op == OP_SET_CG) |=>
        (ac[AW-1] == $past(ac[AW-1]) && ac[AW-2:0] == $past(instr_q.arg[AW-2:0])));

    assert_write_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && instr_q.op == OP_WRITE) |=>
        (ac == ($past(incr) ? AW'($past(ac) + 1'b1) : AW'($past(ac) - 1'b1))));

    assert_fetch_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (dr == $past(fetch_data)));

    assert_dr_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && (instr_q.op == OP_WRITE || instr_q.op == OP_ENTRY)) |=> $stable(dr));

    assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |=> ($stable(ac) && $stable(dr) && $stable(sel_cg) && $stable(incr)));

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && cnt == '0) |=> (state == ST_IDLE));
endmodule

// File: tb/tb_lcd_access_unit.sv
module tb_lcd_access_unit;
    localparam int N = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int e0 = -1000;
    int blen = 0;

    // Reference model state
    int         m_ac = 0;
    bit         m_sel = 1'b0;
    bit         m_inc = 1'b1;
    logic [7:0] m_dr = '0;
    logic [7:0] m_dd [128];
    logic [4:0] m_cg [128];

    lcd_access_unit #(.BUSY_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw),
        .bus_en(bus_en), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit m_busy(int c);
        return (c - e0) < blen;
    endfunction

    function automatic logic [7:0] m_mem();
        return m_sel ? {3'b000, m_cg[m_ac]} : m_dd[m_ac];
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h exp %02h", req, got, exp);
        end
    endtask

    // One bus access; reads are compared with the model, then the model executes
    task automatic op(bit rs, bit rw, logic [7:0] d, string req);
        logic [7:0] got;
        logic [7:0] exp;
        int         f;
        @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_din = d;
        @(negedge clk);
        bus_en = 1'b1;
        @(negedge clk);
        got = bus_dout;
        if (rw) begin
            if (rs) exp = m_dr;
            else    exp = {m_busy(cyc), 7'(m_ac)};
            check(req, got, exp);
        end
        bus_en = 1'b0;
        if (!m_busy(cyc)) begin
            f = -1;
            if (!rs && !rw) begin
                if (d[7]) begin
                    m_ac = int'(d[6:0]); m_sel = 1'b0; m_dr = m_mem(); f = 1;
                end else if (d[6]) begin
                    m_ac = (m_ac & 64) | int'(d[5:0]); m_sel = 1'b1; m_dr = m_mem(); f = 1;
                end else if (d[7:2] == 6'b000001) begin
                    m_inc = d[1]; f = 0;
                end
            end else if (rs && !rw) begin
                if (m_sel) m_cg[m_ac] = d[4:0];
                else       m_dd[m_ac] = d;
                m_ac = (m_ac + (m_inc ? 1 : 127)) % 128;
                f = 0;
            end else if (rs && rw) begin
                m_ac = (m_ac + (m_inc ? 1 : 127)) % 128;
                m_dr = m_mem();
                f = 1;
            end
            if (f >= 0) begin
                e0 = cyc + 1;
                blen = 1 + f + N;
            end
        end
    endtask

    task automatic settle();
        repeat (N + 6) @(negedge clk);
    endtask

    // Per-clock comparison of the bus enable and idle data (R12)
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) begin
                check("R12 oe", {7'b0, bus_oe}, {7'b0, bus_en & bus_rw});
                if (!bus_oe) check("R12 idle data", bus_dout, 8'h00);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 got hang exp finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin m_dd[i] = '0; m_cg[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R4 status format
        op(0, 1, 8'h00, "R1 R4 status after reset");
        op(1, 1, 8'h00, "R1 R8 data register after reset");
        settle();
        // R11 unlisted code: no busy, no change
        op(0, 0, 8'h01, "R11");
        op(0, 1, 8'h00, "R11 status after ignored code");
        // R2 display address, R10 busy visible right after
        op(0, 0, 8'h90, "R2");
        op(0, 1, 8'h00, "R2 R10 status while busy");
        settle();
        op(0, 1, 8'h00, "R2 R10 status after hold");
        // R5 writes with stepping
        op(1, 0, 8'hA5, "R5");
        settle();
        op(1, 0, 8'h3C, "R5");
        settle();
        op(0, 1, 8'h00, "R5 counter after two writes");
        // R10 back-to-back write dropped
        op(1, 0, 8'h77, "R10");
        op(1, 0, 8'h99, "R10 dropped write");
        settle();
        op(0, 1, 8'h00, "R10 counter after dropped write");
        // R8 readback through prefetch
        op(0, 0, 8'h90, "R8"); settle();
        op(1, 1, 8'h00, "R8 first byte"); settle();
        op(1, 1, 8'h00, "R8 second byte"); settle();
        op(1, 1, 8'h00, "R8 R10 kept byte"); settle();
        op(1, 1, 8'h00, "R8 R10 dropped byte absent"); settle();
        // R9 write leaves data register stale
        op(0, 0, 8'hA0, "R9"); settle();
        op(1, 0, 8'h55, "R9"); settle();
        op(0, 0, 8'h04, "R9 R7 entry"); settle();
        op(0, 0, 8'h06, "R7 entry up"); settle();
        op(1, 1, 8'h00, "R9 stale prefetch"); settle();
        // R3 stale bit 6 sends glyph write to upper half
        op(0, 0, 8'hC5, "R3"); settle();
        op(0, 0, 8'h43, "R3"); settle();
        op(0, 1, 8'h00, "R3 bit6 kept"); settle();
        op(1, 0, 8'hFF, "R6"); settle();
        op(0, 0, 8'h83, "R3"); settle();
        op(0, 0, 8'h43, "R3 lower half"); settle();
        op(1, 1, 8'h00, "R3 lower half untouched"); settle();
        op(0, 0, 8'hC3, "R3"); settle();
        op(0, 0, 8'h43, "R3 upper half"); settle();
        op(1, 1, 8'h00, "R6 upper glyph masked"); settle();
        // alternate display access between glyph accesses
        op(0, 0, 8'h91, "R2"); settle();
        op(1, 1, 8'h00, "R8 display after glyph"); settle();
        // R3 bit 6 from stepping
        op(0, 0, 8'hBF, "R3"); settle();
        op(0, 0, 8'h7F, "R3"); settle();
        op(1, 0, 8'h0A, "R6"); settle();
        op(0, 1, 8'h00, "R5 glyph step to 0x40"); settle();
        op(0, 0, 8'h41, "R3 bit6 from step"); settle();
        op(0, 1, 8'h00, "R3 status after step"); settle();
        // R7 down-count with wrap
        op(0, 0, 8'h04, "R7 down"); settle();
        op(0, 0, 8'h80, "R2"); settle();
        op(1, 0, 8'h11, "R5"); settle();
        op(0, 1, 8'h00, "R7 R5 wrap below zero"); settle();
        op(1, 0, 8'h22, "R5"); settle();
        op(0, 1, 8'h00, "R7 second down step"); settle();
        op(0, 0, 8'h06, "R7 up"); settle();
        op(0, 0, 8'hFF, "R2"); settle();
        op(1, 1, 8'h00, "R8 byte at 0x7F"); settle();
        op(1, 1, 8'h00, "R8 R5 wrap to zero"); settle();
        op(0, 1, 8'h00, "R5 counter after wrap"); settle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule